// File: doc/BRIEF.md
# Boot Byte Fetch Controller

This block reads one byte at a time from an external byte-wide boot memory on behalf of a boot loader. A requester pulses a start input together with a 13-bit offset inside an 8 KB page. The block joins that offset with a 3-bit page number held in a small configuration register, which gives a 16-bit byte address. The low 14 address bits go out on the address bus. The top 2 bits share the upper lines of the 24-bit data bus, because the address bus is too narrow to carry them.

A dedicated boot-memory select and a read strobe are driven low together. They stay low for a programmable number of wait states, with the same shape as an ordinary external memory read. On the last active cycle the byte is taken from the middle eight lines of the data bus. The strobes then rise, and a one-cycle completion pulse is presented with the byte.

The data bus is split into output, output-enable and input vectors, so that the tri-state pads sit outside the block.

Top module: `bootrom_fetch`

## Requirements
- R1: After reset, mem_sel_n and mem_rd_n are high, rsp_done is low and every mem_doe bit is 0. The wait field equals the parameter RST_WAIT (default 3) and the page field is 0, so the first access without a configuration write holds the strobes low for 4 cycles at page 0.
- R2: With wait field N (0 to 7), mem_sel_n and mem_rd_n (both active low) go low together in the cycle after an accepted start. They stay low for exactly N+1 cycles.
- R3: The byte address is {page[2:0], offset[12:0]}, 16 bits wide. Bits 13:0 appear on mem_addr and bits 15:14 appear on mem_dout[23:22]. Both stay stable for the whole strobe-low window.
- R4: The byte is taken from mem_din[15:8] on the last strobe-low cycle. It is presented on rsp_byte and held until the next completion. All other mem_din bits are ignored.
- R5: rsp_done is high for exactly one cycle: the cycle right after the last strobe-low cycle.
- R6: A start that arrives while the strobes are low, including on the last low cycle, is ignored. It changes neither the address nor the length of the access, and it starts no further access.
- R7: A configuration write (cfg_wr with cfg_wait and cfg_page) that arrives during an access leaves that access unchanged. It takes effect from the next access. A write made while idle applies to the next start.
- R8: mem_doe[23:22] is 1 only while the strobes are low, and mem_doe[21:0] is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Write strobe for the wait and page fields |
| cfg_wait | input | 3 | New wait-state count |
| cfg_page | input | 3 | New page number |
| req_start | input | 1 | Start pulse for one byte fetch |
| req_offset | input | 13 | Byte offset within the page |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_byte | output | 8 | Captured byte |
| mem_addr | output | 14 | Low address bits to boot memory |
| mem_sel_n | output | 1 | Boot-memory select, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_dout | output | 24 | Data-bus output values (upper address bits) |
| mem_doe | output | 24 | Per-line output enable for the data bus |
| mem_din | input | 24 | Data-bus input values |

## Verification
The bound checker watches these properties on every cycle: strobes fall after each accepted start, no low window runs longer than eight cycles, the address holds during a window, completion follows the last cycle and lasts one cycle, and data-bus enables follow the strobes. Some behaviour only the bench scenarios can show. The exact window length for each wait value needs them, as do the joined page and offset values and the byte picked from the middle lanes against a memory model. They also show that a start during a window is dropped, and that a configuration write mid-access shows up only one access later.

// File: rtl/bootrom_pkg.sv
package bootrom_pkg;
  parameter int WAIT_W   = 3;
  parameter int PAGE_W   = 3;
  parameter int OFF_W    = 13;
  parameter int ABUS_W   = 14;
  parameter int DBUS_W   = 24;
  parameter int BYTE_W   = 8;
  parameter int BYTE_LSB = 8;

  localparam int ADDR_W = PAGE_W + OFF_W;
  localparam int HI_W   = ADDR_W - ABUS_W;
  localparam int HI_LSB = DBUS_W - HI_W;

  // full boot byte address: page above in-page offset
  function automatic logic [ADDR_W-1:0] boot_addr(input logic [PAGE_W-1:0] pg,
                                                   input logic [OFF_W-1:0]  off);
    return {pg, off};
  endfunction

  function automatic logic [ABUS_W-1:0] addr_lo(input logic [ADDR_W-1:0] a);
    return a[ABUS_W-1:0];
  endfunction

  function automatic logic [HI_W-1:0] addr_hi(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: HI_W];
  endfunction

  // returned byte sits in the middle lanes of the data bus
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [DBUS_W-1:0] d);
    return d[BYTE_LSB +: BYTE_W];
  endfunction
endpackage

// File: rtl/bootrom_cfg.sv
module bootrom_cfg
  import bootrom_pkg::*;
#(
  parameter int unsigned RST_WAIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [WAIT_W-1:0] wait_in,
  input  logic [PAGE_W-1:0] page_in,
  output logic [WAIT_W-1:0] wait_q,
  output logic [PAGE_W-1:0] page_q
);
  localparam logic [WAIT_W-1:0] WAIT_INIT = WAIT_W'(RST_WAIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wait_q <= WAIT_INIT;
      page_q <= '0;
    end else if (wr) begin
      wait_q <= wait_in;
      page_q <= page_in;
    end
  end
endmodule

// File: rtl/bootrom_seq.sv
module bootrom_seq
  import bootrom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WAIT_W-1:0] wait_cfg,
  output logic              active,
  output logic              accept,
  output logic              last
);
  localparam logic [WAIT_W-1:0] ONE = {{(WAIT_W-1){1'b0}}, 1'b1};

  logic [WAIT_W-1:0] cnt_q;

  // a start is taken only when no window is open
  assign accept = start && !active;
  assign last   = active && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cnt_q  <= '0;
    end else if (accept) begin
      active <= 1'b1;
      cnt_q  <= wait_cfg;     // wait count snapshot for this access
    end else if (active) begin
      if (cnt_q == '0) active <= 1'b0;
      else             cnt_q  <= cnt_q - ONE;
    end
  end
endmodule

// File: rtl/bootrom_pins.sv
module bootrom_pins
  import bootrom_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              active,
  input  logic              last,
  input  logic [PAGE_W-1:0] page,
  input  logic [OFF_W-1:0]  offset,
  input  logic [DBUS_W-1:0] din,
  output logic [ABUS_W-1:0] addr,
  output logic [DBUS_W-1:0] dout,
  output logic [DBUS_W-1:0] doe,
  output logic              done,
  output logic [BYTE_W-1:0] byte_q
);
  logic [ADDR_W-1:0] addr_q;
  logic [HI_W-1:0]   hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      addr_q <= '0;
    else if (accept) addr_q <= boot_addr(page, offset);
  end

  assign addr = addr_lo(addr_q);
  assign hi   = addr_hi(addr_q);

  // only the upper lanes carry address bits, and only during a window
  for (genvar b = 0; b < DBUS_W; b++) begin : g_lane
    if (b >= HI_LSB) begin : g_hi
      assign dout[b] = hi[b-HI_LSB];
      assign doe[b]  = active;
    end else begin : g_idle
      assign dout[b] = 1'b0;
      assign doe[b]  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      byte_q <= '0;
    end else begin
      done <= last;
      if (last) byte_q <= pick_byte(din);
    end
  end
endmodule

// File: rtl/bootrom_fetch.sv
module bootrom_fetch
  import bootrom_pkg::*;
#(
  parameter int unsigned RST_WAIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [WAIT_W-1:0] cfg_wait,
  input  logic [PAGE_W-1:0] cfg_page,
  input  logic              req_start,
  input  logic [OFF_W-1:0]  req_offset,
  output logic              rsp_done,
  output logic [BYTE_W-1:0] rsp_byte,
  output logic [ABUS_W-1:0] mem_addr,
  output logic              mem_sel_n,
  output logic              mem_rd_n,
  output logic [DBUS_W-1:0] mem_dout,
  output logic [DBUS_W-1:0] mem_doe,
  input  logic [DBUS_W-1:0] mem_din
);
  logic [WAIT_W-1:0] wait_q;
  logic [PAGE_W-1:0] page_q;
  logic              acc_active;
  logic              acc_start;
  logic              acc_last;

  bootrom_cfg #(.RST_WAIT(RST_WAIT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr),
    .wait_in(cfg_wait), .page_in(cfg_page),
    .wait_q(wait_q), .page_q(page_q)
  );

  bootrom_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(req_start), .wait_cfg(wait_q),
    .active(acc_active), .accept(acc_start), .last(acc_last)
  );

  bootrom_pins u_pins (
    .clk(clk), .rst_n(rst_n), .accept(acc_start), .active(acc_active),
    .last(acc_last), .page(page_q), .offset(req_offset), .din(mem_din),
    .addr(mem_addr), .dout(mem_dout), .doe(mem_doe),
    .done(rsp_done), .byte_q(rsp_byte)
  );

  assign mem_sel_n = ~acc_active;
  assign mem_rd_n  = ~acc_active;
endmodule

// File: rtl/bootrom_fetch_chk.sv
module bootrom_fetch_chk
  import bootrom_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_start,
  input logic              mem_sel_n,
  input logic              mem_rd_n,
  input logic [ABUS_W-1:0] mem_addr,
  input logic [DBUS_W-1:0] mem_doe,
  input logic              rsp_done,
  input logic              acc_start,
  input logic              acc_last
);
  localparam int LEN_W = WAIT_W + 1;
  localparam logic [LEN_W-1:0] MAXLEN = LEN_W'(1 << WAIT_W);
  localparam logic [DBUS_W-1:0] HI_EN = {{HI_W{1'b1}}, {HI_LSB{1'b0}}};

  logic [LEN_W-1:0] len_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          len_q <= '0;
    else if (!mem_sel_n) len_q <= len_q + LEN_W'(1);
    else                 len_q <= '0;
  end

  assert_start_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> (!mem_sel_n && !mem_rd_n));

  assert_len_max_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_sel_n |-> (len_q < MAXLEN));

  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && !acc_last) |=> ($stable(mem_addr) && !mem_sel_n));

  assert_done_after_last_R5: assert property (@(posedge clk) disable iff (!rst_n)
    acc_last |=> (rsp_done && mem_sel_n));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_last && req_start) |=> mem_sel_n);

  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_doe == (mem_sel_n ? '0 : HI_EN));
endmodule

bind bootrom_fetch bootrom_fetch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_start(req_start),
  .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_addr(mem_addr),
  .mem_doe(mem_doe), .rsp_done(rsp_done),
  .acc_start(acc_start), .acc_last(acc_last)
);

// File: tb/sim_bootrom_fetch.sv
module sim_bootrom_fetch;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [2:0]  cfg_wait = '0;
  logic [2:0]  cfg_page = '0;
  logic        req_start = 1'b0;
  logic [12:0] req_offset = '0;
  logic        rsp_done;
  logic [7:0]  rsp_byte;
  logic [13:0] mem_addr;
  logic        mem_sel_n, mem_rd_n;
  logic [23:0] mem_dout, mem_doe, mem_din;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;

  always #4 clk = ~clk;   // 125 MHz

  bootrom_fetch u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wait(cfg_wait),
    .cfg_page(cfg_page), .req_start(req_start), .req_offset(req_offset),
    .rsp_done(rsp_done), .rsp_byte(rsp_byte), .mem_addr(mem_addr),
    .mem_sel_n(mem_sel_n), .mem_rd_n(mem_rd_n), .mem_dout(mem_dout),
    .mem_doe(mem_doe), .mem_din(mem_din)
  );

  // memory model: content depends on all 16 address bits
  function automatic logic [7:0] mem_f(input logic [15:0] a);
    return (a[7:0] ^ a[15:8]) + 8'h5A;
  endfunction

  logic [15:0] seen_addr;
  assign seen_addr = {mem_doe[23:22] & mem_dout[23:22], mem_addr};
  // junk in the side lanes so only bits 15:8 may be used
  assign mem_din = (!mem_sel_n && !mem_rd_n) ? {8'hC3, mem_f(seen_addr), 8'h3C}
                                             : 24'hA5A5A5;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: actual=%0d expected<=50000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input logic [2:0] w, input logic [2:0] p);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_wait = w; cfg_page = p;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // one access; optional extra start (R6) or config write (R7) at low cycle k
  task automatic run_fetch(input logic [12:0] off, input int exp_n,
                           input logic [2:0] exp_pg, input int poke_at,
                           input int cfg_at, input logic [2:0] nw,
                           input logic [2:0] np);
    logic [15:0] ea;
    int k;
    int guard;
    bit addr_ok, pair_ok, done_ok, oe_ok;
    logic [15:0] bad_addr;
    ea = {exp_pg, off};
    k = 0; guard = 0;
    addr_ok = 1; pair_ok = 1; done_ok = 1; oe_ok = 1; bad_addr = '0;
    @(negedge clk);
    req_start = 1'b1; req_offset = off;
    forever begin
      @(negedge clk);
      req_start = 1'b0; cfg_wr = 1'b0;
      guard++;
      if (mem_sel_n != mem_rd_n) pair_ok = 0;
      if (!mem_sel_n) begin
        k++;
        if (seen_addr != ea) begin addr_ok = 0; bad_addr = seen_addr; end
        if (mem_doe != 24'hC00000) oe_ok = 0;
        if (rsp_done) done_ok = 0;
        if (k == poke_at) begin req_start = 1'b1; req_offset = off ^ 13'h1555; end
        if (k == cfg_at) begin cfg_wr = 1'b1; cfg_wait = nw; cfg_page = np; end
      end else if (rsp_done || guard > 20) begin
        break;
      end
    end
    chk(rsp_done == 1'b1, "R5", "done after window", rsp_done, 1);
    chk(k == exp_n, "R2", "strobe-low cycles", k, exp_n);
    chk(pair_ok, "R2", "select and read strobe paired", {31'b0, pair_ok}, 1);
    chk(addr_ok, "R3", "16-bit address on buses", bad_addr, ea);
    chk(rsp_byte == mem_f(ea), "R4", "captured byte", rsp_byte, mem_f(ea));
    chk(oe_ok && mem_doe == '0, "R8", "data-bus enables", mem_doe, 0);
    chk(done_ok, "R5", "no done during window", {31'b0, done_ok}, 1);
    @(negedge clk);
    chk(rsp_done == 1'b0, "R5", "done lasts one cycle", rsp_done, 0);
    chk(rsp_byte == mem_f(ea), "R4", "byte held", rsp_byte, mem_f(ea));
    if (poke_at > 0) begin
      for (int i = 0; i < 3; i++) begin
        chk(mem_sel_n && !rsp_done, "R6", "no access from ignored start",
            {mem_sel_n, rsp_done}, 2'b10);
        @(negedge clk);
      end
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(mem_sel_n && mem_rd_n, "R1", "strobes idle in reset", {mem_sel_n, mem_rd_n}, 2'b11);
    chk(rsp_done == 1'b0, "R1", "done low in reset", rsp_done, 0);
    chk(mem_doe == '0, "R1", "bus released in reset", mem_doe, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_sel_n && !rsp_done, "R1", "idle after reset", {mem_sel_n, rsp_done}, 2'b10);
    // default wait 3 and page 0
    run_fetch(13'h0123, 4, 3'd0, 0, 0, 3'd0, 3'd0);
  endtask

  task automatic t_waits();
    for (int w = 0; w < 8; w++) begin
      set_cfg(3'(w), 3'(w));
      run_fetch(13'(w * 13'h0321 + 13'h0011), w + 1, 3'(w), 0, 0, 3'd0, 3'd0);
    end
  endtask

  task automatic t_pages();
    set_cfg(3'd2, 3'd5);
    run_fetch(13'h0000, 3, 3'd5, 0, 0, 3'd0, 3'd0);
    run_fetch(13'h1FFF, 3, 3'd5, 0, 0, 3'd0, 3'd0);
    run_fetch(13'h0AAA, 3, 3'd5, 0, 0, 3'd0, 3'd0);
    set_cfg(3'd1, 3'd7);
    run_fetch(13'h1234, 2, 3'd7, 0, 0, 3'd0, 3'd0);
  endtask

  task automatic t_busy_start();
    set_cfg(3'd3, 3'd1);
    run_fetch(13'h0456, 4, 3'd1, 2, 0, 3'd0, 3'd0);   // R6 mid window
    run_fetch(13'h0789, 4, 3'd1, 4, 0, 3'd0, 3'd0);   // R6 on last cycle
  endtask

  task automatic t_cfg_midway();
    set_cfg(3'd5, 3'd2);
    run_fetch(13'h0F0F, 6, 3'd2, 0, 3, 3'd1, 3'd6);   // R7 current access unchanged
    run_fetch(13'h0F0F, 2, 3'd6, 0, 0, 3'd0, 3'd0);   // R7 next access uses new values
  endtask

  initial begin
    t_reset();
    t_waits();
    t_pages();
    t_busy_start();
    t_cfg_midway();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule